// File: doc/BRIEF.md
# Bus Event Interval Timer

This block times the gap between two events seen on an observed processor bus. A start event and a stop event are each recognised when a completed bus cycle carries a programmed address. Typical uses are a routine's entry and exit fetches, or an interrupt request acknowledge and the first fetch of its handler. Each finished interval is reported as a duration and folded into running minimum, maximum and occurrence count values. A host clears these statistics with a one-clock command.

A programmable deadline turns the timer into a watchdog for latency. If the stop event has not arrived when the running duration reaches the limit, a one-clock alarm is raised so that trace capture or a break can be triggered. The interval is then dropped. A separate watcher flags a bus cycle that stays pending for a programmed number of clocks without completing, such as an access to an address that nothing decodes.

Top module: `iv_timer`

## Requirements
- R1: A start event is a clock in which `bus_valid` and `bus_done` are both 1 and `bus_addr` equals `cfg_start_addr`. A stop event is the same condition with `cfg_stop_addr`. Clocks in which either strobe is 0 produce no event.
- R2: On a stop event that is K clocks after the start event, `last_dur` becomes K in the clock after the stop event.
- R3: With `cfg_limit` nonzero, when the duration reaches `cfg_limit` without a stop event, `alarm` is 1 for exactly one clock and the interval is abandoned. A later stop event is ignored. A stop event at exactly `cfg_limit` clocks completes normally. A `cfg_limit` of 0 disables the alarm.
- R4: Each completed interval lowers `min_dur` if its duration is smaller and raises `max_dur` if its duration is larger.
- R5: `evt_count` rises by one per completed interval and holds at all ones instead of wrapping.
- R6: A start event during a running interval restarts the measurement from that event. A stop event while no interval runs changes no output.
- R7: The duration holds at all ones (2^CW-1) instead of wrapping.
- R8: `stats_clear` sets `min_dur` to all ones and sets `max_dur` and `evt_count` to zero. It takes priority over a completion in the same clock and leaves `last_dur` unchanged.
- R9: With `cfg_hang_limit` nonzero, a bus cycle held pending (`bus_valid` 1, `bus_done` 0) for `cfg_hang_limit` consecutive clocks raises `hang` for exactly one clock, once per cycle. A cycle that completes earlier raises nothing.
- R10: After reset, `last_dur` is 0, `min_dur` is all ones, `max_dur` is 0, `evt_count` is 0, and `alarm` and `hang` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus cycle is in progress |
| bus_done | input | 1 | The bus cycle completes this clock |
| bus_addr | input | AW | Address of the current bus cycle |
| cfg_start_addr | input | AW | Address that starts an interval |
| cfg_stop_addr | input | AW | Address that ends an interval |
| cfg_limit | input | CW | Deadline in clocks, 0 disables |
| cfg_hang_limit | input | HW | Pending-cycle limit in clocks, 0 disables |
| stats_clear | input | 1 | Clear minimum, maximum and count |
| last_dur | output | CW | Duration of the last completed interval |
| min_dur | output | CW | Smallest completed duration |
| max_dur | output | CW | Largest completed duration |
| evt_count | output | NW | Completed interval count |
| alarm | output | 1 | Deadline missed, one-clock pulse |
| hang | output | 1 | Bus cycle pending too long, one-clock pulse |

## Verification
The bench builds the block with AW=8, CW=6, NW=3 and HW=4. A 6-bit duration lets one interval of 81 clocks reach the duration ceiling of 63. A 3-bit count lets nine short intervals push the count past its ceiling of 7. A 4-bit pending counter keeps the hang window at five clocks. Under these settings the deadline edge, restart, saturation and clear cases each take only tens of clocks.

// File: rtl/iv_pkg.sv
package iv_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int EV_START = 0;
    localparam int EV_STOP  = 1;
    localparam int EV_NUM   = 2;
endpackage

// File: rtl/iv_match.sv
module iv_match #(
    parameter int AW = 16
) (
    input  logic          bus_valid,
    input  logic          bus_done,
    input  logic [AW-1:0] bus_addr,
    input  logic [AW-1:0] ref_addr,
    output logic          hit
);
    always_comb begin
        hit = bus_valid && bus_done && (bus_addr == ref_addr);
    end
endmodule

// File: rtl/iv_hang.sv
module iv_hang #(
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_done,
    input  logic [HW-1:0] limit,
    output logic          hang
);
    typedef struct packed {
        logic [HW-1:0] cnt;
        logic          fired;
        logic          pulse;
    } hst_t;

    hst_t hs_d, hs_q;
    logic pending;

    always_comb begin
        hs_d       = hs_q;
        hs_d.pulse = 1'b0;
        pending    = bus_valid && !bus_done;
        if (!pending) begin
            hs_d.cnt   = '0;
            hs_d.fired = 1'b0;
        end else if (!hs_q.fired && limit != '0) begin
            if (hs_q.cnt == limit - 1'b1) begin
                hs_d.pulse = 1'b1;
                hs_d.fired = 1'b1;
            end else begin
                hs_d.cnt = hs_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign hang = hs_q.pulse;

    // R9: one pulse per stuck cycle
    a_r9_hang_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        hang |=> !hang);
endmodule

// File: rtl/iv_timer.sv
module iv_timer #(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int NW = 16,
    parameter int HW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic          bus_done,
    input  logic [AW-1:0] bus_addr,
    input  logic [AW-1:0] cfg_start_addr,
    input  logic [AW-1:0] cfg_stop_addr,
    input  logic [CW-1:0] cfg_limit,
    input  logic [HW-1:0] cfg_hang_limit,
    input  logic          stats_clear,
    output logic [CW-1:0] last_dur,
    output logic [CW-1:0] min_dur,
    output logic [CW-1:0] max_dur,
    output logic [NW-1:0] evt_count,
    output logic          alarm,
    output logic          hang
);
    import iv_pkg::*;

    localparam logic [CW-1:0] DUR_MAX = {CW{1'b1}};
    localparam logic [NW-1:0] CNT_MAX = {NW{1'b1}};

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] dur;
        logic [CW-1:0] last;
        logic [CW-1:0] mn;
        logic [CW-1:0] mx;
        logic [NW-1:0] cnt;
        logic          tmo;
    } st_t;

    logic [AW-1:0]     refs [EV_NUM];
    logic [EV_NUM-1:0] hit;

    assign refs[EV_START] = cfg_start_addr;
    assign refs[EV_STOP]  = cfg_stop_addr;

    for (genvar g = 0; g < EV_NUM; g++) begin : g_cmp
        iv_match #(.AW(AW)) u_cmp (
            .bus_valid (bus_valid),
            .bus_done  (bus_done),
            .bus_addr  (bus_addr),
            .ref_addr  (refs[g]),
            .hit       (hit[g])
        );
    end

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tmo = 1'b0;
        if (hit[EV_START]) begin
            st_d.ph  = PH_RUN;
            st_d.dur = {{(CW-1){1'b0}}, 1'b1};
        end else if (st_q.ph == PH_RUN) begin
            if (hit[EV_STOP]) begin
                st_d.ph   = PH_IDLE;
                st_d.last = st_q.dur;
                if (st_q.dur < st_q.mn) st_d.mn = st_q.dur;
                if (st_q.dur > st_q.mx) st_d.mx = st_q.dur;
                if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
            end else if (cfg_limit != '0 && st_q.dur >= cfg_limit) begin
                st_d.tmo = 1'b1;
                st_d.ph  = PH_IDLE;
            end else if (st_q.dur != DUR_MAX) begin
                st_d.dur = st_q.dur + 1'b1;
            end
        end
        if (stats_clear) begin
            st_d.mn  = DUR_MAX;
            st_d.mx  = '0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ph  <= PH_IDLE;
            st_q.mn  <= DUR_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign last_dur  = st_q.last;
    assign min_dur   = st_q.mn;
    assign max_dur   = st_q.mx;
    assign evt_count = st_q.cnt;
    assign alarm     = st_q.tmo;

    iv_hang #(.HW(HW)) u_hang (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_valid (bus_valid),
        .bus_done  (bus_done),
        .limit     (cfg_hang_limit),
        .hang      (hang)
    );

    // R3: alarm never lasts two clocks
    a_r3_alarm_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm |=> !alarm);

    // R4: once anything is recorded, min cannot exceed max
    a_r4_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_count != '0) |-> (min_dur <= max_dur));

    // R5: count moves by at most one without a clear
    a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        !stats_clear |=> (evt_count == $past(evt_count)) ||
                         (evt_count == $past(evt_count) + 1'b1));

    // R6: stop while idle leaves results untouched
    a_r6_idle_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && hit[EV_STOP] && !hit[EV_START] && !stats_clear)
        |=> $stable(last_dur) && $stable(evt_count));
endmodule

// File: tb/iv_timer_test.sv
module iv_timer_test;
    localparam int AW = 8;
    localparam int CW = 6;
    localparam int NW = 3;
    localparam int HW = 4;
    localparam logic [AW-1:0] A_GO  = 8'h12;
    localparam logic [AW-1:0] A_END = 8'h34;
    localparam int NV = 4;
    localparam int VK   [NV] = '{5, 3, 9, 4};
    localparam int VMIN [NV] = '{5, 3, 3, 3};
    localparam int VMAX [NV] = '{5, 5, 9, 9};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0, bus_done = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [CW-1:0] cfg_limit = '0;
    logic [HW-1:0] cfg_hang_limit = '0;
    logic stats_clear = 1'b0;
    logic [CW-1:0] last_dur, min_dur, max_dur;
    logic [NW-1:0] evt_count;
    logic alarm, hang;
    int total = 0, bad = 0, alarms = 0;

    always #2.5 clk = ~clk;

    iv_timer #(.AW(AW), .CW(CW), .NW(NW), .HW(HW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_done(bus_done),
        .bus_addr(bus_addr), .cfg_start_addr(A_GO), .cfg_stop_addr(A_END),
        .cfg_limit(cfg_limit), .cfg_hang_limit(cfg_hang_limit),
        .stats_clear(stats_clear), .last_dur(last_dur), .min_dur(min_dur),
        .max_dur(max_dur), .evt_count(evt_count), .alarm(alarm), .hang(hang)
    );

    always @(posedge clk) if (rst_n && alarm) alarms++;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cyc(input logic [AW-1:0] a);
        bus_valid = 1'b1; bus_done = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0; bus_done = 1'b0; bus_addr = '0;
    endtask

    task automatic interval(input int k);
        cyc(A_GO);
        idle(k - 1);
        cyc(A_END);
    endtask

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk("R10 last", last_dur, 0);
        chk("R10 min", min_dur, 63);
        chk("R10 max", max_dur, 0);
        chk("R10 count", evt_count, 0);
        chk("R10 alarm", alarm, 0);
        chk("R10 hang", hang, 0);

        cfg_limit = 6'd20;
        for (int i = 0; i < NV; i++) begin
            interval(VK[i]);
            chk("R2 last", last_dur, VK[i]);
            chk("R4 min", min_dur, VMIN[i]);
            chk("R4 max", max_dur, VMAX[i]);
            chk("R5 count", evt_count, i + 1);
        end

        // R1: right address without done, and done with other address: no event
        bus_valid = 1'b1; bus_addr = A_GO; idle(1);
        bus_addr = 8'h55; bus_done = 1'b1; idle(1);
        bus_valid = 1'b0; bus_done = 1'b0; bus_addr = '0;
        cyc(A_END);
        chk("R1 no event count", evt_count, 4);
        chk("R1 no event last", last_dur, 4);

        // R3: stop exactly at the limit completes
        cfg_limit = 6'd10;
        interval(10);
        chk("R3 at limit last", last_dur, 10);
        chk("R3 at limit count", evt_count, 5);
        chk("R3 at limit no alarm", alarms, 0);

        // R3: deadline missed
        cyc(A_GO);
        idle(9);
        chk("R3 before deadline", alarm, 0);
        idle(1);
        chk("R3 alarm raised", alarm, 1);
        idle(1);
        chk("R3 alarm one clock", alarm, 0);
        cyc(A_END);
        chk("R3 late stop ignored", evt_count, 5);
        chk("R3 alarm total", alarms, 1);

        // R6: stop while idle
        cyc(A_END);
        chk("R6 idle stop last", last_dur, 10);
        chk("R6 idle stop count", evt_count, 5);

        // R6: restart
        cyc(A_GO); idle(3); cyc(A_GO); idle(2); cyc(A_END);
        chk("R6 restart last", last_dur, 3);
        chk("R6 restart count", evt_count, 6);

        // R7: saturation with alarm disabled
        cfg_limit = '0;
        cyc(A_GO); idle(80); cyc(A_END);
        chk("R7 saturated last", last_dur, 63);
        chk("R7 max", max_dur, 63);
        chk("R3 limit zero no alarm", alarms, 1);

        // R8: clear
        stats_clear = 1'b1; idle(1); stats_clear = 1'b0;
        chk("R8 min", min_dur, 63);
        chk("R8 max", max_dur, 0);
        chk("R8 count", evt_count, 0);
        chk("R8 last kept", last_dur, 63);

        // R8: clear wins over completion
        cyc(A_GO); idle(1);
        stats_clear = 1'b1; cyc(A_END); stats_clear = 1'b0;
        chk("R8 priority count", evt_count, 0);
        chk("R8 priority last", last_dur, 2);

        // R5: count saturation
        for (int i = 0; i < 9; i++) interval(2);
        chk("R5 saturated count", evt_count, 7);
        chk("R4 min after", min_dur, 2);

        // R9: hang watcher
        cfg_hang_limit = 4'd5;
        bus_valid = 1'b1; bus_addr = 8'h77;
        idle(3);
        bus_done = 1'b1; idle(1); bus_done = 1'b0;
        chk("R9 early finish", hang, 0);
        idle(4);
        chk("R9 before limit", hang, 0);
        idle(1);
        chk("R9 hang raised", hang, 1);
        idle(1);
        chk("R9 hang one clock", hang, 0);
        idle(3);
        chk("R9 no repeat", hang, 0);
        bus_valid = 1'b0;
        idle(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule